// File: doc/BRIEF.md
# Switchable-Window Video Address Mapper

This block sits between a host CPU bus and an external pattern memory on the video side. A small register is written by any CPU store into the upper half of the CPU address space. It holds a bank number and a mirroring choice. The video address space of 8 KiB is split into two parts. The lowest 6 KiB always map to the first three 2 KiB pages of the memory. The top 2 KiB window, where video address bits 12 and 11 are both set, maps to whichever page the register names.

The block also drives the memory output enable from the CPU read/write line. The memory therefore never drives the data bus while the CPU is writing the register, and the register write cannot collide with memory data. A third output picks the nametable RAM page bit from video address bit 10 or bit 11, which gives vertical or horizontal mirroring.

The number of physical pages is a parameter. Bank numbers that exceed it wrap around.

Top module: `latched_bank_mapper`

## Requirements
- R1: When video address bits 12 and 11 are not both 1, `mem_addr[10:0]` equals `vid_addr[10:0]` and the page bits `mem_addr[MEM_AW-1:11]` equal zero-extended {vid_addr[12], vid_addr[11]}.
- R2: When video address bits 12 and 11 are both 1, the page bits equal the stored bank number modulo NUM_BANKS, and `mem_addr[10:0]` equals `vid_addr[10:0]`.
- R3: A cycle with `cpu_strobe`=1, `cpu_rw`=0 and `cpu_addr[15]`=1 loads the register. The bank number is taken from `cpu_data[3:0]` and the mirroring bit from `cpu_data[4]`. Bits 7:5 are ignored.
- R4: A cycle without a qualifying write leaves both bank and mirroring bit unchanged. This covers reads, writes with `cpu_addr[15]`=0, and cycles with no strobe.
- R5: A synchronous reset (`rst_n`=0 at a clock edge) clears the bank number and the mirroring bit to 0.
- R6: `mem_oe_n` is the inverse of `cpu_rw`. It is 1 during any CPU write cycle and 0 during reads.
- R7: With the mirroring bit at 0, `ntram_a10` follows `vid_addr[10]` (vertical). With the mirroring bit at 1, it follows `vid_addr[11]` (horizontal).
- R8: A register write takes effect at the clock edge that ends the write cycle. Outputs during the write cycle still reflect the old value.
- R9: With NUM_BANKS=8, a stored bank value of 8 to 15 selects page value−8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_strobe | input | 1 | Valid bus cycle this clock |
| vid_addr | input | 14 | Video-side address |
| mem_addr | output | MEM_AW | Pattern memory address |
| mem_oe_n | output | 1 | Pattern memory output enable, active low |
| ntram_a10 | output | 1 | Nametable RAM page bit |

## Verification
A register write and a video fetch inside the switchable window can fall in the same cycle. The bench provokes this both by random stimulus and by directed writes issued while `vid_addr` sits at the window. It judges the result by requiring the window page seen during the write cycle to match the old bank number and the page seen in the next cycle to match the new one. The same overlap is checked for the mirroring bit by holding `vid_addr` with bits 10 and 11 at opposite values across a write that flips mirroring.

// File: rtl/mapper_pkg.sv
// Package: shared constants and the stored mapper state type.
// Assumes a 2 KiB page granularity on the video side.
package mapper_pkg;
    localparam int PAGE_BITS  = 11;   // address bits inside one page
    localparam int VID_AW     = 14;   // video address width
    localparam int BANK_FIELD = 4;    // stored bank number width

    typedef struct packed {
        logic                  mirror_h;  // 1 = horizontal mirroring
        logic [BANK_FIELD-1:0] bank;      // window page number
    } map_state_t;
endpackage

// File: rtl/bank_register.sv
// Module: bank_register
// Holds the bank number and mirroring bit. Loads on a qualified CPU write
// at the closing clock edge; clears on synchronous active-low reset.
// Assumes cpu_rw=0 marks a write and cpu_strobe marks a valid cycle.
module bank_register
    import mapper_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_strobe,
    input  logic        cpu_rw,
    input  logic        cpu_a15,
    input  logic [7:0]  cpu_data,
    output map_state_t  state_q
);
    logic load;

    // Qualify a register write: valid cycle, write, upper CPU half
    always_comb begin
        load = cpu_strobe && !cpu_rw && cpu_a15;
    end

    // State register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load) begin
            state_q.bank     <= cpu_data[BANK_FIELD-1:0];
            state_q.mirror_h <= cpu_data[4];
        end
    end

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q.bank == $past(cpu_data[3:0]) &&
                  state_q.mirror_h == $past(cpu_data[4])));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(state_q));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == '0));
endmodule

// File: rtl/window_mux.sv
// Module: window_mux
// Builds the pattern memory address. The top 2 KiB of the 8 KiB space
// (bits 12 and 11 both set) take the stored bank; the rest map to pages 0..2.
// Assumes BANK_W >= 2 so the fixed pages fit.
module window_mux
    import mapper_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic [VID_AW-1:0]          vid_addr,
    input  logic [BANK_FIELD-1:0]      bank,
    output logic [BANK_W+PAGE_BITS-1:0] mem_addr
);
    logic              in_window;
    logic [BANK_W-1:0] fixed_hi;
    logic [BANK_W-1:0] switch_hi;
    logic [BANK_W-1:0] page_hi;

    // Window decode and page selection
    always_comb begin
        in_window    = vid_addr[12] & vid_addr[11];
        fixed_hi     = '0;
        fixed_hi[1:0] = vid_addr[12:11];
        switch_hi    = BANK_W'(bank);   // truncation gives modulo wrap
        page_hi      = in_window ? switch_hi : fixed_hi;
        mem_addr     = {page_hi, vid_addr[PAGE_BITS-1:0]};
    end

    // Fixed region never reaches beyond the third page
    always_comb begin
        if (!in_window) begin
            assert_fixed_page_R1: assert (mem_addr[BANK_W+PAGE_BITS-1:PAGE_BITS] < 3);
        end
    end
endmodule

// File: rtl/mirror_select.sv
// Module: mirror_select
// Chooses the nametable page bit: video bit 10 (vertical) or bit 11
// (horizontal). Assumes a single 2:1 choice is all that is needed.
module mirror_select
    import mapper_pkg::*;
(
    input  logic [VID_AW-1:0] vid_addr,
    input  logic              mirror_h,
    output logic              ntram_a10
);
    // 2:1 selection of the page bit
    always_comb begin
        ntram_a10 = mirror_h ? vid_addr[11] : vid_addr[10];
    end
endmodule

// File: rtl/latched_bank_mapper.sv
// Module: latched_bank_mapper
// Top level: bank register, window address mux, mirroring select and the
// memory output enable. NUM_BANKS must be a power of two, 4..16.
module latched_bank_mapper
    import mapper_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int MEM_AW   = BANK_W + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_strobe,
    input  logic [13:0]       vid_addr,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic              ntram_a10
);
    map_state_t state_q;

    bank_register u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_strobe (cpu_strobe),
        .cpu_rw     (cpu_rw),
        .cpu_a15    (cpu_addr[15]),
        .cpu_data   (cpu_data),
        .state_q    (state_q)
    );

    window_mux #(.BANK_W(BANK_W)) u_win (
        .vid_addr (vid_addr),
        .bank     (state_q.bank),
        .mem_addr (mem_addr)
    );

    mirror_select u_mir (
        .vid_addr  (vid_addr),
        .mirror_h  (state_q.mirror_h),
        .ntram_a10 (ntram_a10)
    );

    // Memory drives the bus only on reads, so register writes cannot clash
    always_comb begin
        mem_oe_n = ~cpu_rw;
    end

    // During any write cycle the memory must be off the bus
    always_comb begin
        if (cpu_strobe && !cpu_rw) begin
            assert_oe_off_on_write_R6: assert (mem_oe_n);
        end
    end

    // Page bit follows the selected video address bit for the stored mode
    assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_addr[10] != vid_addr[11]) |->
            (ntram_a10 == (state_q.mirror_h ? vid_addr[11] : vid_addr[10])));
endmodule

// File: tb/tb_latched_bank_mapper.sv
// Bench: directed corner cases plus seeded random cycles, checked against
// a model built from the requirements.
module tb_latched_bank_mapper;
    localparam int NB = 8;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [15:0]   cpu_addr;
    logic [7:0]    cpu_data;
    logic          cpu_rw;
    logic          cpu_strobe;
    logic [13:0]   vid_addr;
    logic [AW-1:0] mem_addr;
    logic          mem_oe_n;
    logic          ntram_a10;

    int checks = 0;
    int fails  = 0;
    int exp_bank = 0;
    int exp_mir  = 0;

    always #2 clk = ~clk;   // 250 MHz

    latched_bank_mapper #(.NUM_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_strobe(cpu_strobe), .vid_addr(vid_addr),
        .mem_addr(mem_addr), .mem_oe_n(mem_oe_n), .ntram_a10(ntram_a10)
    );

    function automatic int exp_addr(input int v, input int bank);
        int hi;
        if (((v >> 12) & 1) == 1 && ((v >> 11) & 1) == 1) hi = bank % NB;
        else hi = (v >> 11) & 3;
        return (hi << 11) | (v & 11'h7ff);
    endfunction

    function automatic int exp_nt(input int v, input int mir);
        return mir != 0 ? ((v >> 11) & 1) : ((v >> 10) & 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check before posedge, update model
    task automatic bus_cycle(input logic strb, input logic rw, input logic [15:0] a,
                             input logic [7:0] d, input logic [13:0] v);
        @(negedge clk);
        cpu_strobe = strb; cpu_rw = rw; cpu_addr = a; cpu_data = d; vid_addr = v;
        #1;
        check("R1/R2/R8 mem_addr", int'(mem_addr), exp_addr(int'(v), exp_bank));
        check("R6 mem_oe_n", int'(mem_oe_n), int'(!rw));
        check("R7 ntram_a10", int'(ntram_a10), exp_nt(int'(v), exp_mir));
        @(posedge clk);
        if (strb && !rw && a[15]) begin
            exp_bank = int'(d[3:0]);
            exp_mir  = int'(d[4]);
        end
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; cpu_strobe = 0; cpu_rw = 1; cpu_addr = '0; cpu_data = '0;
        vid_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R5: reset state, window shows page 0, vertical mirroring
        vid_addr = 14'h1C00; #1;
        check("R5 window page after reset", int'(mem_addr), 14'h0400);
        check("R5 mirror after reset", int'(ntram_a10), 1);
        // R1 fixed pages
        bus_cycle(0, 1, 16'h0000, 8'h00, 14'h0123);
        bus_cycle(0, 1, 16'h0000, 8'h00, 14'h0923);
        bus_cycle(0, 1, 16'h0000, 8'h00, 14'h1123);
        // R3/R8: write bank 5 while fetching in the window; old value same cycle
        bus_cycle(1, 0, 16'h8000, 8'hE5, 14'h1FFF);
        bus_cycle(0, 1, 16'h0000, 8'h00, 14'h1FFF);
        check("R2 window page 5", int'(mem_addr[13:11]), 5);
        // R4: writes below 0x8000, reads and idle strobe leave state alone
        bus_cycle(1, 0, 16'h7FFF, 8'h13, 14'h1800);
        bus_cycle(1, 1, 16'hC000, 8'h13, 14'h1800);
        bus_cycle(0, 0, 16'hC000, 8'h13, 14'h1800);
        bus_cycle(0, 1, 16'h0000, 8'h00, 14'h1800);
        check("R4 bank unchanged", int'(mem_addr[13:11]), 5);
        // R7: flip mirroring across a write with bits 10/11 differing
        bus_cycle(1, 0, 16'hFFFF, 8'h12, 14'h0800);
        bus_cycle(0, 1, 16'h0000, 8'h00, 14'h0800);
        check("R7 horizontal uses bit 11", int'(ntram_a10), 1);
        // R9: bank values above the page count wrap
        bus_cycle(1, 0, 16'h9000, 8'h0F, 14'h1800);
        bus_cycle(0, 1, 16'h0000, 8'h00, 14'h1800);
        check("R9 bank 15 wraps to 7", int'(mem_addr[13:11]), 7);
        bus_cycle(1, 0, 16'h9000, 8'h08, 14'h1800);
        bus_cycle(0, 1, 16'h0000, 8'h00, 14'h1800);
        check("R9 bank 8 wraps to 0", int'(mem_addr[13:11]), 0);
        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [13:0] v;
            v = 14'($urandom);
            if ((i % 3) == 0) v[12:11] = 2'b11;
            bus_cycle(1'($urandom), 1'($urandom), 16'($urandom), 8'($urandom), v);
        end
        // R5: reset clears a nonzero state
        bus_cycle(1, 0, 16'h8000, 8'h16, 14'h1800);
        @(negedge clk); rst_n = 1'b0; cpu_strobe = 0;
        @(posedge clk);
        @(negedge clk); rst_n = 1'b1; vid_addr = 14'h1C00; #1;
        exp_bank = 0; exp_mir = 0;
        check("R5 bank cleared", int'(mem_addr[13:11]), 0);
        check("R5 mirror cleared", int'(ntram_a10), 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule